// File: doc/BRIEF.md
# Dual-Rail Logic Gate Array Without Early Evaluation

This block is a bank of combinational dual-rail gates. Every logical bit is carried on two wires, a false rail and a true rail. One of the two rails high marks a valid bit. Both rails equal marks a spacer token, which carries no value. A two-bit operation select picks AND, OR, XOR or NOT. The chosen gate is applied lane by lane to two dual-rail buses of parameterised width.

In the default build, a gate never gives a valid result from an incomplete operand set. If any operand it reads is a spacer, its output is a spacer. This holds even where the other operand alone would fix the Boolean answer. A corrupted rail pair therefore turns into a spacer token that carries no trace of the value it replaced. It cannot become a wrong value that looks valid.

A build parameter selects an early-evaluating variant with plain rail equations, so the two behaviours can be compared side by side. Each operand pair of every lane has a fault-override input: an enable plus a forced rail pair. Test benches use it to inject symmetric and asymmetric faults.

Top module: `dr_gate_array`

## Requirements
- R1: Rail pairs are written {false rail, true rail}. Logic 0 is {1,0} and logic 1 is {0,1}; these are valid. With op_sel = 0 (AND) and both operands valid, each lane outputs the valid encoding of the Boolean AND.
- R2: With op_sel = 1 (OR) and both operands valid, each lane outputs the valid encoding of the Boolean OR.
- R3: With op_sel = 2 (XOR) and both operands valid, each lane outputs the valid encoding of the Boolean XOR.
- R4: With op_sel = 3 (NOT), each lane outputs operand A with its two rails swapped. A valid bit is inverted, a spacer stays the same spacer, and operand B has no effect on the output.
- R5: The spacer tokens are {0,0} (low spacer) and {1,1} (high spacer). In the default build (EARLY_EVAL = 0), an AND, OR or XOR lane with a spacer on either operand outputs a spacer. This holds even when the other operand alone decides the Boolean result.
- R6: In the default build, when exactly one operand of a two-input lane is a spacer, the output is that same spacer token.
- R7: In the default build, when both operands of a two-input lane are spacers, the output is that token if they are equal. If they differ, the output is the low spacer {0,0}.
- R8: In the default build, a low spacer on one operand and a high spacer on the other never gives a valid output, for any operation.
- R9: When a lane's fault enable for an operand is 1, the forced rail pair replaces that operand. When the enable is 0, the forced pair has no effect.
- R10: With EARLY_EVAL = 1, AND gives false = fA|fB and true = tA&tB. OR gives false = fA&fB and true = tA|tB. XOR gives true = tA&fB | fA&tB and false = fA&fB | tA&tB. NOT swaps the rails. As a result, a valid 0 on one AND operand gives a valid 0 against a spacer, and a low spacer ANDed with a high spacer gives a valid 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 2 | Operation: 0 AND, 1 OR, 2 XOR, 3 NOT (on A) |
| a_f | input | WIDTH | Operand A false rails |
| a_t | input | WIDTH | Operand A true rails |
| b_f | input | WIDTH | Operand B false rails |
| b_t | input | WIDTH | Operand B true rails |
| flt_a_en | input | WIDTH | Per-lane fault override enable for operand A |
| flt_a_f | input | WIDTH | Forced false rail for operand A |
| flt_a_t | input | WIDTH | Forced true rail for operand A |
| flt_b_en | input | WIDTH | Per-lane fault override enable for operand B |
| flt_b_f | input | WIDTH | Forced false rail for operand B |
| flt_b_t | input | WIDTH | Forced true rail for operand B |
| y_f | output | WIDTH | Result false rails |
| y_t | output | WIDTH | Result true rails |

## Verification
Every one of the sixteen operand pair combinations is sent through every operation on both builds. A default build that evaluated early would give a valid 0 for an AND of logic 0 with a spacer, and a valid 0 for an AND of a low spacer with a high spacer. Faults are injected through the override inputs, both symmetric (to either spacer) and asymmetric (to mixed spacers). A broken override would pass the true operand through or let a disabled forced pair leak into the result. A wrong spacer choice would show up as a token other than the one the input carried. The NOT path is driven with spacers on operand B to show that B is ignored.

// File: rtl/dr_pkg.sv
// Package: shared dual-rail types, token constants and the operation code.
// Assumes a rail pair is packed {f, t}; valid when exactly one rail is high.
package dr_pkg;

    typedef struct packed {
        logic f;
        logic t;
    } rail_t;

    typedef enum logic [1:0] {
        OP_AND = 2'd0,
        OP_OR  = 2'd1,
        OP_XOR = 2'd2,
        OP_NOT = 2'd3
    } dr_op_e;

    localparam rail_t RAIL_ZERO = '{f: 1'b1, t: 1'b0};
    localparam rail_t RAIL_ONE  = '{f: 1'b0, t: 1'b1};
    localparam rail_t SPACER_LO = '{f: 1'b0, t: 1'b0};
    localparam rail_t SPACER_HI = '{f: 1'b1, t: 1'b1};

    // A pair carries a value only when its rails disagree.
    function automatic logic is_valid(rail_t r);
        return r.f ^ r.t;
    endfunction

    // Encode a Boolean value as a valid rail pair.
    function automatic rail_t encode(logic v);
        return v ? RAIL_ONE : RAIL_ZERO;
    endfunction

endpackage

// File: rtl/dr_fault_force.sv
// Module: per-pair fault override. When the enable is high the forced pair
// replaces the incoming pair; otherwise the pair passes unchanged.
// Assumes a purely combinational path, with no storage.
module dr_fault_force
    import dr_pkg::*;
(
    input  rail_t d_in,
    input  logic  en,
    input  rail_t force_val,
    output rail_t d_out
);

    // Select forced or functional pair.
    always_comb begin
        d_out = en ? force_val : d_in;
    end

endmodule

// File: rtl/dr_gate_cell.sv
// Module: one dual-rail gate lane. EARLY_EVAL picks the variant. With 0, any
// spacer operand gives a spacer out. With 1, the plain rail equations
// let one operand decide the result.
// Assumes NOT reads operand A only.
module dr_gate_cell
    import dr_pkg::*;
#(
    parameter bit EARLY_EVAL = 1'b0
) (
    input  dr_op_e op,
    input  rail_t  a,
    input  rail_t  b,
    output rail_t  y
);

    generate
        if (EARLY_EVAL) begin : g_early
            // Plain rail equations; no completeness test on operands.
            always_comb begin
                unique case (op)
                    OP_AND:  y = '{f: a.f | b.f, t: a.t & b.t};
                    OP_OR:   y = '{f: a.f & b.f, t: a.t | b.t};
                    OP_XOR:  y = '{f: (a.f & b.f) | (a.t & b.t),
                                   t: (a.t & b.f) | (a.f & b.t)};
                    default: y = '{f: a.t, t: a.f};
                endcase
            end
        end else begin : g_complete
            logic a_ok;
            logic b_ok;
            logic bool_res;
            rail_t spacer_out;

            // Operand validity flags.
            always_comb begin
                a_ok = is_valid(a);
                b_ok = is_valid(b);
            end

            // Boolean result on the true rails, meaningful only when both are valid.
            always_comb begin
                unique case (op)
                    OP_AND:  bool_res = a.t & b.t;
                    OP_OR:   bool_res = a.t | b.t;
                    default: bool_res = a.t ^ b.t;
                endcase
            end

            // Pick the spacer to emit: the lone spacer, a shared one, else low.
            always_comb begin
                if (!a_ok && b_ok)
                    spacer_out = a;
                else if (a_ok && !b_ok)
                    spacer_out = b;
                else if (a == b)
                    spacer_out = a;
                else
                    spacer_out = SPACER_LO;
            end

            // Output mux: NOT swaps rails, others need both operands valid.
            always_comb begin
                if (op == OP_NOT)
                    y = '{f: a.t, t: a.f};
                else if (a_ok && b_ok)
                    y = encode(bool_res);
                else
                    y = spacer_out;
            end

            // Lane-level checks on the completeness rule.
            always_comb begin
                if (op != OP_NOT && !(is_valid(a) && is_valid(b)))
                    AST_SPACER_IN_SPACER_OUT: assert (!is_valid(y)) else $error("spacer in gave valid out"); // R5
                if (op != OP_NOT && a == SPACER_LO && b == SPACER_HI)
                    AST_MIXED_NEVER_VALID: assert (!is_valid(y)) else $error("mixed spacers gave valid out"); // R8
                if (op != OP_NOT && !is_valid(a) && is_valid(b))
                    AST_LONE_SPACER_KEPT: assert (y == a) else $error("lone spacer not kept"); // R6
                if (op != OP_NOT && is_valid(a) && is_valid(b))
                    AST_VALID_IN_VALID_OUT: assert (is_valid(y)) else $error("valid in gave spacer"); // R1
                if (op == OP_NOT)
                    AST_NOT_KEEPS_CLASS: assert (is_valid(y) == is_valid(a)) else $error("NOT changed class"); // R4
            end
        end
    endgenerate

endmodule

// File: rtl/dr_gate_vec.sv
// Module: WIDTH lanes, each a fault override on both operands feeding one
// gate cell. All lanes share the operation select.
// Assumes the override pairs are already packed per lane.
module dr_gate_vec
    import dr_pkg::*;
#(
    parameter int WIDTH      = 8,
    parameter bit EARLY_EVAL = 1'b0
) (
    input  dr_op_e            op,
    input  rail_t [WIDTH-1:0] a_in,
    input  rail_t [WIDTH-1:0] b_in,
    input  logic  [WIDTH-1:0] a_en,
    input  rail_t [WIDTH-1:0] a_frc,
    input  logic  [WIDTH-1:0] b_en,
    input  rail_t [WIDTH-1:0] b_frc,
    output rail_t [WIDTH-1:0] y_out
);

    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_lane
            rail_t a_eff;
            rail_t b_eff;

            dr_fault_force u_force_a (
                .d_in     (a_in[i]),
                .en       (a_en[i]),
                .force_val(a_frc[i]),
                .d_out    (a_eff)
            );

            dr_fault_force u_force_b (
                .d_in     (b_in[i]),
                .en       (b_en[i]),
                .force_val(b_frc[i]),
                .d_out    (b_eff)
            );

            dr_gate_cell #(
                .EARLY_EVAL(EARLY_EVAL)
            ) u_cell (
                .op(op),
                .a (a_eff),
                .b (b_eff),
                .y (y_out[i])
            );

            // A forced spacer must reach the lane output as a spacer.
            always_comb begin
                if (!EARLY_EVAL && op != OP_NOT &&
                    ((a_en[i] && !is_valid(a_frc[i])) || (b_en[i] && !is_valid(b_frc[i]))))
                    AST_FORCED_SPACER_SEEN: assert (!is_valid(y_out[i])) else $error("forced spacer lost"); // R9
            end
        end
    endgenerate

endmodule

// File: rtl/dr_gate_array.sv
// Module: top of the dual-rail gate bank. Splits flat rail vectors into
// packed pairs, runs the lane vector and flattens the result.
// Assumes op_sel is stable while operands are being evaluated.
module dr_gate_array
    import dr_pkg::*;
#(
    parameter int WIDTH      = 8,
    parameter bit EARLY_EVAL = 1'b0
) (
    input  logic [1:0]       op_sel,
    input  logic [WIDTH-1:0] a_f,
    input  logic [WIDTH-1:0] a_t,
    input  logic [WIDTH-1:0] b_f,
    input  logic [WIDTH-1:0] b_t,
    input  logic [WIDTH-1:0] flt_a_en,
    input  logic [WIDTH-1:0] flt_a_f,
    input  logic [WIDTH-1:0] flt_a_t,
    input  logic [WIDTH-1:0] flt_b_en,
    input  logic [WIDTH-1:0] flt_b_f,
    input  logic [WIDTH-1:0] flt_b_t,
    output logic [WIDTH-1:0] y_f,
    output logic [WIDTH-1:0] y_t
);

    dr_op_e            op;
    rail_t [WIDTH-1:0] a_pair;
    rail_t [WIDTH-1:0] b_pair;
    rail_t [WIDTH-1:0] fa_pair;
    rail_t [WIDTH-1:0] fb_pair;
    rail_t [WIDTH-1:0] y_pair;

    // Decode the operation select.
    always_comb begin
        op = dr_op_e'(op_sel);
    end

    // Pack flat rails into per-lane pairs and unpack the result.
    always_comb begin
        for (int k = 0; k < WIDTH; k++) begin
            a_pair[k]  = '{f: a_f[k],     t: a_t[k]};
            b_pair[k]  = '{f: b_f[k],     t: b_t[k]};
            fa_pair[k] = '{f: flt_a_f[k], t: flt_a_t[k]};
            fb_pair[k] = '{f: flt_b_f[k], t: flt_b_t[k]};
            y_f[k]     = y_pair[k].f;
            y_t[k]     = y_pair[k].t;
        end
    end

    dr_gate_vec #(
        .WIDTH     (WIDTH),
        .EARLY_EVAL(EARLY_EVAL)
    ) u_vec (
        .op   (op),
        .a_in (a_pair),
        .b_in (b_pair),
        .a_en (flt_a_en),
        .a_frc(fa_pair),
        .b_en (flt_b_en),
        .b_frc(fb_pair),
        .y_out(y_pair)
    );

endmodule

// File: tb/test_dr_gate_array.sv
// Directed bench: both builds, exhaustive pairs, faults, NOT path.
module test_dr_gate_array;

    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [1:0]   op_sel;
    logic [W-1:0] a_f, a_t, b_f, b_t;
    logic [W-1:0] fa_en, fa_f, fa_t, fb_en, fb_f, fb_t;
    logic [W-1:0] y_f, y_t, e_f, e_t;

    int checks = 0;
    int errors = 0;

    dr_gate_array #(.WIDTH(W), .EARLY_EVAL(1'b0)) i_dr_gate_array (
        .op_sel(op_sel), .a_f(a_f), .a_t(a_t), .b_f(b_f), .b_t(b_t),
        .flt_a_en(fa_en), .flt_a_f(fa_f), .flt_a_t(fa_t),
        .flt_b_en(fb_en), .flt_b_f(fb_f), .flt_b_t(fb_t),
        .y_f(y_f), .y_t(y_t)
    );

    dr_gate_array #(.WIDTH(W), .EARLY_EVAL(1'b1)) i_dr_gate_array_early (
        .op_sel(op_sel), .a_f(a_f), .a_t(a_t), .b_f(b_f), .b_t(b_t),
        .flt_a_en(fa_en), .flt_a_f(fa_f), .flt_a_t(fa_t),
        .flt_b_en(fb_en), .flt_b_f(fb_f), .flt_b_t(fb_t),
        .y_f(e_f), .y_t(e_t)
    );

    // Three-value view of a pair {f,t}: 0, 1, or 2 meaning X.
    function automatic int tri_val(logic [1:0] p);
        if (p == 2'b10) return 0;
        if (p == 2'b01) return 1;
        return 2;
    endfunction

    // Expected result of the default build, from the requirements.
    function automatic logic [1:0] exp_complete(logic [1:0] op, logic [1:0] a, logic [1:0] b);
        int va, vb, r;
        if (op == 2'd3) return {a[0], a[1]};
        va = tri_val(a);
        vb = tri_val(b);
        if (va == 2 && vb == 2) return (a == b) ? a : 2'b00;
        if (va == 2) return a;
        if (vb == 2) return b;
        case (op)
            2'd0: r = va & vb;
            2'd1: r = va | vb;
            default: r = va ^ vb;
        endcase
        return (r != 0) ? 2'b01 : 2'b10;
    endfunction

    // Expected result of the early build, from its rail equations.
    function automatic logic [1:0] exp_early(logic [1:0] op, logic [1:0] a, logic [1:0] b);
        logic fa, ta, fb, tb;
        {fa, ta} = a;
        {fb, tb} = b;
        case (op)
            2'd0: return {fa | fb, ta & tb};
            2'd1: return {fa & fb, ta | tb};
            2'd2: return {(fa & fb) | (ta & tb), (ta & fb) | (fa & tb)};
            default: return {ta, fa};
        endcase
    endfunction

    task automatic check(string req, int lane, logic [1:0] got, logic [1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s lane %0d got %b expected %b", req, lane, got, exp);
        end
    endtask

    task automatic clear_faults();
        fa_en = '0; fa_f = '0; fa_t = '0;
        fb_en = '0; fb_f = '0; fb_t = '0;
    endtask

    task automatic set_lane(int i, logic [1:0] pa, logic [1:0] pb);
        a_f[i] = pa[1]; a_t[i] = pa[0];
        b_f[i] = pb[1]; b_t[i] = pb[0];
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    // Idle: all spacer operands give spacer outputs on both builds.
    task automatic t_idle();
        op_sel = 2'd0;
        a_f = '0; a_t = '0; b_f = '0; b_t = '0;
        clear_faults();
        settle();
        for (int i = 0; i < W; i++) begin
            check("R5 idle", i, {y_f[i], y_t[i]}, 2'b00);
            check("R10 idle", i, {e_f[i], e_t[i]}, 2'b00);
        end
    endtask

    // All sixteen operand pair combinations for one operation.
    task automatic t_exhaustive(logic [1:0] op);
        op_sel = op;
        clear_faults();
        for (int rnd = 0; rnd < 2; rnd++) begin
            for (int i = 0; i < W; i++) begin
                logic [3:0] k;
                k = 4'(rnd * W + i);
                set_lane(i, k[3:2], k[1:0]);
            end
            settle();
            for (int i = 0; i < W; i++) begin
                logic [3:0] k;
                logic [1:0] pa, pb;
                string tag;
                k = 4'(rnd * W + i);
                pa = k[3:2];
                pb = k[1:0];
                if (op == 2'd3) tag = "R4";
                else if (tri_val(pa) != 2 && tri_val(pb) != 2)
                    tag = (op == 2'd0) ? "R1" : (op == 2'd1) ? "R2" : "R3";
                else if (tri_val(pa) == 2 && tri_val(pb) == 2) tag = "R7";
                else tag = "R6 R5";
                check(tag, i, {y_f[i], y_t[i]}, exp_complete(op, pa, pb));
                check("R10", i, {e_f[i], e_t[i]}, exp_early(op, pa, pb));
            end
        end
    endtask

    // Mixed spacers: default build never valid, early AND gives valid 0.
    task automatic t_mixed_spacers();
        clear_faults();
        for (int o = 0; o < 3; o++) begin
            op_sel = 2'(o);
            for (int i = 0; i < W; i++)
                set_lane(i, (i % 2 == 0) ? 2'b00 : 2'b11, (i % 2 == 0) ? 2'b11 : 2'b00);
            settle();
            for (int i = 0; i < W; i++) begin
                checks++;
                if (tri_val({y_f[i], y_t[i]}) != 2) begin
                    errors++;
                    $display("FAIL R8 op %0d lane %0d got %b expected spacer", o, i, {y_f[i], y_t[i]});
                end
                if (o == 0) check("R10 mixed", i, {e_f[i], e_t[i]}, 2'b10);
            end
        end
        // Valid 0 against a spacer: early decides, default does not.
        op_sel = 2'd0;
        set_lane(0, 2'b10, 2'b00);
        set_lane(1, 2'b11, 2'b10);
        settle();
        check("R5 and0-spacer", 0, {y_f[0], y_t[0]}, 2'b00);
        check("R5 spacer-and0", 1, {y_f[1], y_t[1]}, 2'b11);
        check("R10 and0-spacer", 0, {e_f[0], e_t[0]}, 2'b10);
        check("R10 spacer-and0", 1, {e_f[1], e_t[1]}, 2'b10);
    endtask

    // Fault override: symmetric and asymmetric forcing, and disabled leak.
    task automatic t_faults();
        logic [1:0] exp;
        op_sel = 2'd0;
        clear_faults();
        for (int i = 0; i < W; i++) set_lane(i, 2'b01, 2'b01);
        // Lanes 0,1: A forced to low / high spacer.
        fa_en[0] = 1'b1; fa_f[0] = 1'b0; fa_t[0] = 1'b0;
        fa_en[1] = 1'b1; fa_f[1] = 1'b1; fa_t[1] = 1'b1;
        // Lane 2: B forced to high spacer.
        fb_en[2] = 1'b1; fb_f[2] = 1'b1; fb_t[2] = 1'b1;
        // Lane 3: asymmetric, A low spacer and B high spacer.
        fa_en[3] = 1'b1; fb_en[3] = 1'b1; fb_f[3] = 1'b1; fb_t[3] = 1'b1;
        // Lane 4: A forced to valid 0.
        fa_en[4] = 1'b1; fa_f[4] = 1'b1; fa_t[4] = 1'b0;
        // Lanes 5..7: forced values present but disabled.
        for (int i = 5; i < W; i++) begin
            fa_f[i] = 1'b1; fa_t[i] = 1'b0; fb_f[i] = 1'b0; fb_t[i] = 1'b0;
        end
        settle();
        check("R9 R6 force A lo", 0, {y_f[0], y_t[0]}, 2'b00);
        check("R9 R6 force A hi", 1, {y_f[1], y_t[1]}, 2'b11);
        check("R9 R6 force B hi", 2, {y_f[2], y_t[2]}, 2'b11);
        check("R9 R7 asym", 3, {y_f[3], y_t[3]}, 2'b00);
        check("R9 force valid0", 4, {y_f[4], y_t[4]}, 2'b10);
        for (int i = 5; i < W; i++)
            check("R9 disabled", i, {y_f[i], y_t[i]}, 2'b01);
        exp = exp_early(2'd0, 2'b00, 2'b11);
        check("R10 asym", 3, {e_f[3], e_t[3]}, exp);
        clear_faults();
    endtask

    // NOT ignores operand B entirely.
    task automatic t_not_ignores_b();
        op_sel = 2'd3;
        clear_faults();
        for (int i = 0; i < W; i++)
            set_lane(i, (i % 2 == 0) ? 2'b10 : 2'b01, 2'(i % 4));
        fb_en = '1; fb_f = 8'h5A; fb_t = 8'hA5;
        settle();
        for (int i = 0; i < W; i++)
            check("R4 B ignored", i, {y_f[i], y_t[i]}, (i % 2 == 0) ? 2'b01 : 2'b10);
        clear_faults();
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        op_sel = '0;
        a_f = '0; a_t = '0; b_f = '0; b_t = '0;
        clear_faults();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        t_idle();
        for (int o = 0; o < 4; o++) t_exhaustive(2'(o));
        t_mixed_spacers();
        t_faults();
        t_not_ignores_b();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule